// File: doc/BRIEF.md
# Closed Caption Line Scheduler

This block keeps one caption byte pair per video field and places it on that field's caption line. The host writes two bytes per field through a small write port. Each field has a status bit that tells the host whether its last pair is still waiting or has already gone out. A two-bit enable field chooses which fields carry captions. The video timing side supplies four inputs: a line-start pulse, the current line number, a field identifier and a broadcast standard select. On the matching line the block gives a one-cycle insert strobe together with the byte pair that the downstream caption waveform generator must send.

When the caption line of an enabled field arrives and no new pair has been committed since the last insertion, the block still asserts the strobe. In that case it supplies the null pair 0x80, 0x80, so the line always carries a valid caption packet. Writes to a field that is not enabled are discarded, and that field's status bit reads 1.

Top module: `cc_line_sched`

## Requirements
- R1: `field_en[0]` enables captions on the first field and `field_en[1]` enables them on the second field. With `field_en` = 00 no insert strobe ever occurs.
- R2: `field_id` = 0 marks the first field. Its caption line is 21 for `std_sel` = 0 (NTSC), 18 for `std_sel` = 1 (M-PAL), and 22 for `std_sel` = 2 or 3 (other PAL).
- R3: `field_id` = 1 marks the second field. Its caption line is 284 for NTSC, 281 for M-PAL and 335 for other PAL.
- R4: `cc_insert` is high for exactly one cycle. That cycle immediately follows a cycle in which `line_start` is 1, the field is enabled and `line_num` equals that field's caption line. A line match without `line_start` gives no strobe.
- R5: Write addresses map as follows. Address 0 writes the first byte of the first field and address 1 writes its second byte. Addresses 2 and 3 do the same for the second field. A write of the second byte commits the pair {first byte, second byte}, and the pair later appears as `cc_byte0`, `cc_byte1`.
- R6: A write to either byte of a field whose enable bit is 0 is ignored. After the field is enabled, its next insertion does not carry the ignored data.
- R7: A field's `wr_status` bit reads 0 from the cycle after a commit until that pair is inserted, and reads 1 from the cycle after the insertion. If a commit and an insertion of the same field fall in the same cycle, the old state is inserted and the new pair stays pending.
- R8: While a field's enable bit is 0, its `wr_status` bit reads 1.
- R9: An insertion with no pair pending outputs `cc_byte0` = `cc_byte1` = 0x80.
- R10: After reset, `cc_insert` is 0, both bytes are 0x80 and `wr_status` is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_en | input | 2 | Per-field caption enable (bit 0 first field, bit 1 second field) |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host byte address (field in bit 1, byte in bit 0) |
| wr_data | input | 8 | Host write data |
| wr_status | output | 2 | Per-field status: 0 pair pending, 1 pair sent or field disabled |
| std_sel | input | 2 | Standard: 0 NTSC, 1 M-PAL, 2/3 other PAL |
| field_id | input | 1 | Current field: 0 first, 1 second |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | 10 | Current line number |
| cc_insert | output | 1 | One-cycle strobe: insert caption on this line |
| cc_byte0 | output | 8 | First caption byte of the inserted pair |
| cc_byte1 | output | 8 | Second caption byte of the inserted pair |

## Verification
The hardest case to reach is a commit landing in the same cycle as the insertion of that field. In that case the old pending state must be sent and the new pair must stay pending. Random stimulus seldom lines these two events up. A directed step therefore drives the second-byte write and the `line_start` pulse on the caption line in one cycle. A second hard case is data written while a field is disabled, which must not appear later. The stimulus toggles the enables between writes and then compares the next insertion against the null pair. Random operations are biased toward exact caption lines over all standards, and that bias gives frequent hits.

// File: rtl/cc_sched_pkg.sv
package cc_sched_pkg;

  localparam int LINE_W = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    STD_NTSC   = 2'd0,
    STD_MPAL   = 2'd1,
    STD_PAL    = 2'd2,
    STD_PAL_B  = 2'd3
  } std_e;

  // First-field line; the second field sits a half-frame of lines later.
  function automatic int unsigned first_line(input logic [1:0] std);
    case (std)
      STD_NTSC: first_line = 21;
      STD_MPAL: first_line = 18;
      default:  first_line = 22;
    endcase
  endfunction

  function automatic int unsigned field_offset(input logic [1:0] std);
    case (std)
      STD_NTSC, STD_MPAL: field_offset = 263;
      default:            field_offset = 313;
    endcase
  endfunction

  function automatic int unsigned caption_line(input logic [1:0] std,
                                               input logic second);
    caption_line = first_line(std) + (second ? field_offset(std) : 0);
  endfunction

endpackage

// File: rtl/cc_line_match.sv
module cc_line_match
  import cc_sched_pkg::*;
#(
  parameter int LW = LINE_W
) (
  input  logic [1:0]    std_sel,
  input  logic          field_id,
  input  logic [LW-1:0] line_num,
  input  logic          line_start,
  input  logic [1:0]    field_en,
  output logic          hit
);
  logic [LW-1:0] target;
  always_comb begin
    target = LW'(caption_line(std_sel, field_id));
    hit    = line_start && field_en[field_id] && (line_num == target);
  end
endmodule

// File: rtl/cc_field_slot.sv
module cc_field_slot #(
  parameter int          BW        = 8,
  parameter logic [7:0]  NULL_BYTE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enabled,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  input  logic          take,
  output logic [BW-1:0] tx_lo,
  output logic [BW-1:0] tx_hi,
  output logic          pending
);
  logic [BW-1:0] stage_q, lo_q, hi_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      pend_q  <= 1'b0;
    end else if (!enabled) begin
      pend_q <= 1'b0;
    end else begin
      if (wr_lo) stage_q <= wr_data;
      if (wr_hi) begin
        lo_q   <= stage_q;
        hi_q   <= wr_data;
        pend_q <= 1'b1;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign tx_lo   = pend_q ? lo_q : BW'(NULL_BYTE);
  assign tx_hi   = pend_q ? hi_q : BW'(NULL_BYTE);
  assign pending = pend_q;
endmodule

// File: rtl/cc_line_sched.sv
module cc_line_sched
  import cc_sched_pkg::*;
#(
  parameter int         LW        = LINE_W,
  parameter int         BW        = BYTE_W,
  parameter logic [7:0] NULL_BYTE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    field_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [1:0]    wr_status,
  input  logic [1:0]    std_sel,
  input  logic          field_id,
  input  logic          line_start,
  input  logic [LW-1:0] line_num,
  output logic          cc_insert,
  output logic [BW-1:0] cc_byte0,
  output logic [BW-1:0] cc_byte1
);
  localparam int NFIELD = 2;

  logic          line_hit;
  logic [NFIELD-1:0] take_evt;
  logic [NFIELD-1:0] pend;
  logic [BW-1:0] tx_lo [NFIELD];
  logic [BW-1:0] tx_hi [NFIELD];

  cc_line_match #(.LW(LW)) u_match (
    .std_sel(std_sel), .field_id(field_id), .line_num(line_num),
    .line_start(line_start), .field_en(field_en), .hit(line_hit)
  );

  for (genvar f = 0; f < NFIELD; f++) begin : g_slot
    logic sel_f;
    assign sel_f       = wr_en && (wr_addr[1] == f[0]);
    assign take_evt[f] = line_hit && (field_id == f[0]);
    cc_field_slot #(.BW(BW), .NULL_BYTE(NULL_BYTE)) u_slot (
      .clk(clk), .rst_n(rst_n), .enabled(field_en[f]),
      .wr_lo(sel_f && !wr_addr[0]), .wr_hi(sel_f && wr_addr[0]),
      .wr_data(wr_data), .take(take_evt[f]),
      .tx_lo(tx_lo[f]), .tx_hi(tx_hi[f]), .pending(pend[f])
    );
    assign wr_status[f] = !field_en[f] || !pend[f];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_insert <= 1'b0;
      cc_byte0  <= BW'(NULL_BYTE);
      cc_byte1  <= BW'(NULL_BYTE);
    end else begin
      cc_insert <= line_hit;
      if (line_hit) begin
        cc_byte0 <= tx_lo[field_id];
        cc_byte1 <= tx_hi[field_id];
      end
    end
  end
endmodule

// File: rtl/cc_line_sched_checker.sv
module cc_line_sched_checker #(
  parameter int LW = 10,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    field_en,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [1:0]    wr_status,
  input logic          field_id,
  input logic          line_start,
  input logic [LW-1:0] line_num,
  input logic          cc_insert,
  input logic [BW-1:0] cc_byte0,
  input logic [BW-1:0] cc_byte1
);
  p_insert_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_insert |-> $past(line_start) && $past(field_en[field_id]));

  p_insert_on_caption_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cc_insert |-> ($past(line_num) inside {LW'(18), LW'(21), LW'(22),
                                           LW'(281), LW'(284), LW'(335)}));

  p_commit_clears_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && field_en[0]) |=> (!field_en[0] || !wr_status[0]));

  p_disabled_status_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_en[1] && !field_en[0]) |-> wr_status == 2'b11);

  p_null_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_insert && $past(field_id ? wr_status[1] : wr_status[0]))
      |-> (cc_byte0 == BW'(8'h80) && cc_byte1 == BW'(8'h80)));
endmodule

bind cc_line_sched cc_line_sched_checker #(.LW(LW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_en(field_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_status(wr_status), .field_id(field_id),
  .line_start(line_start), .line_num(line_num), .cc_insert(cc_insert),
  .cc_byte0(cc_byte0), .cc_byte1(cc_byte1)
);

// File: tb/cc_line_sched_test.sv
`timescale 1ns/1ps
module cc_line_sched_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] field_en = 2'b00;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] wr_status;
  logic [1:0] std_sel = 0;
  logic       field_id = 0;
  logic       line_start = 0;
  logic [9:0] line_num = 0;
  logic       cc_insert;
  logic [7:0] cc_byte0, cc_byte1;

  int checks = 0, fails = 0;
  logic       m_pend [2];
  logic [7:0] m_lo [2], m_hi [2], m_stage [2];

  always #10 clk = ~clk;

  cc_line_sched uut (.*);

  function automatic int exp_line(input logic [1:0] s, input logic f);
    int tbl [8] = '{21, 18, 22, 22, 284, 281, 335, 335};
    return tbl[{f, s}];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_status(input string req);
    logic [1:0] e;
    for (int f = 0; f < 2; f++) e[f] = !field_en[f] || !m_pend[f];
    chk(wr_status == e, req, wr_status, e);
  endtask

  task automatic set_en(input logic [1:0] en);
    @(negedge clk);
    field_en = en;
    for (int f = 0; f < 2; f++) if (!en[f]) m_pend[f] = 0;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (field_en[a[1]]) begin
      if (!a[0]) m_stage[a[1]] = d;
      else begin
        m_lo[a[1]] = m_stage[a[1]]; m_hi[a[1]] = d; m_pend[a[1]] = 1;
      end
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  // Drives a line start; optional simultaneous commit write (address a, data d).
  task automatic line_pulse(input logic f, input int ln, input string req,
                            input bit with_wr = 0, input logic [1:0] a = 0,
                            input logic [7:0] d = 0);
    bit hit; logic [7:0] e0, e1;
    @(negedge clk);
    line_start = 1; field_id = f; line_num = 10'(ln);
    hit = field_en[f] && (ln == exp_line(std_sel, f));
    e0 = m_pend[f] ? m_lo[f] : 8'h80;
    e1 = m_pend[f] ? m_hi[f] : 8'h80;
    if (hit) m_pend[f] = 0;
    if (with_wr) begin
      wr_en = 1; wr_addr = a; wr_data = d;
      if (field_en[a[1]]) begin
        if (!a[0]) m_stage[a[1]] = d;
        else begin
          m_lo[a[1]] = m_stage[a[1]]; m_hi[a[1]] = d; m_pend[a[1]] = 1;
        end
      end
    end
    @(negedge clk);
    line_start = 0; wr_en = 0;
    chk(cc_insert == hit, req, cc_insert, hit);
    if (hit) chk({cc_byte0, cc_byte1} == {e0, e1}, req, {cc_byte0, cc_byte1}, {e0, e1});
    chk_status(req);
    @(negedge clk);
    chk(cc_insert == 0, "R4 single-cycle strobe", cc_insert, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'd4242;
    void'($urandom(seed));
    for (int f = 0; f < 2; f++) begin
      m_pend[f] = 0; m_lo[f] = 0; m_hi[f] = 0; m_stage[f] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(cc_insert == 0 && cc_byte0 == 8'h80 && cc_byte1 == 8'h80,
        "R10 reset outputs", {cc_insert, cc_byte0, cc_byte1}, {1'b0, 16'h8080});
    chk(wr_status == 2'b11, "R10 reset status", wr_status, 3);

    // R1 code 00: no strobe on any caption line
    for (int s = 0; s < 4; s++) begin
      std_sel = 2'(s);
      line_pulse(0, exp_line(2'(s), 0), "R1 code 00 first");
      line_pulse(1, exp_line(2'(s), 1), "R1 code 00 second");
    end

    // R8 / R6 writes while disabled ignored
    host_write(2'd0, 8'h11); host_write(2'd1, 8'h22);
    chk(wr_status == 2'b11, "R8 disabled status", wr_status, 3);
    set_en(2'b01);
    chk_status("R6 no pending after enable");
    std_sel = 0;
    line_pulse(0, 21, "R6 R9 ignored write gives null pair");

    // R1 code 01: second field still off
    line_pulse(1, 284, "R1 code 01 second off");

    // R5 R7 commit, status, output
    host_write(2'd0, 8'h41); chk_status("R7 first byte keeps status");
    host_write(2'd1, 8'h42); chk_status("R7 commit clears status");
    line_pulse(0, 22, "R2 off-by-one line");
    line_pulse(0, 20, "R2 line below");
    line_pulse(1, 21, "R4 wrong field");
    @(negedge clk); line_num = 10'd21; field_id = 0;
    @(negedge clk);
    chk(cc_insert == 0, "R4 no strobe without line_start", cc_insert, 0);
    line_pulse(0, 21, "R5 R7 pair inserted");
    line_pulse(0, 21, "R9 null after send");

    // R3 second field across standards, code 10 and 11
    set_en(2'b10);
    for (int s = 0; s < 4; s++) begin
      std_sel = 2'(s);
      host_write(2'd2, 8'(8'hA0 + s)); host_write(2'd3, 8'(8'hB0 + s));
      line_pulse(0, exp_line(2'(s), 0), "R1 code 10 first off");
      line_pulse(1, exp_line(2'(s), 1), "R3 second-field line");
    end
    set_en(2'b11);
    for (int s = 0; s < 4; s++) begin
      std_sel = 2'(s);
      host_write(2'd0, 8'(8'h10 + s)); host_write(2'd1, 8'(8'h20 + s));
      line_pulse(0, exp_line(2'(s), 0), "R2 first-field line");
      line_pulse(1, exp_line(2'(s), 1), "R3 R9 second null");
    end

    // R7 commit and insertion of same field in one cycle
    std_sel = 0;
    host_write(2'd0, 8'h55); host_write(2'd1, 8'h66);
    host_write(2'd0, 8'h77);
    line_pulse(0, 21, "R7 same-cycle commit", 1, 2'd1, 8'h88);
    line_pulse(0, 21, "R7 new pair after collision");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) host_write(2'($urandom_range(0, 3)), 8'($urandom));
      else if (op == 4) set_en(2'($urandom_range(0, 3)));
      else if (op == 5) std_sel = 2'($urandom_range(0, 3));
      else begin
        logic f = 1'($urandom_range(0, 1));
        int ln = ($urandom_range(0, 1) == 1) ? exp_line(std_sel, f)
                                              : int'($urandom_range(0, 400));
        line_pulse(f, ln, "R4 random line");
      end
      chk_status("R7 R8 random status");
    end
    finish_run();
  end
endmodule